// File: doc/BRIEF.md
# Random Bit-Flip Fault Injector

This block sits between the processing elements of a multiprocessor fabric and whatever observes their results. It corrupts the data word of one element at a time by XOR-ing a flip mask onto it. The corruption models single upsets and multiple-bit upsets. Injection is allowed only while the chosen element reports that it is executing a task. The inter-element links are never touched. A free-running maximal-length LFSR supplies three things: the moment of injection, the target element and the flipped bit positions. Injection is tied to the clock at a programmable rate, so a campaign can raise the fault load step by step and measure how detection and re-execution cope.

Each campaign fixes the number of bits flipped per fault, from one to four. Between faults the block assembles a mask of exactly that many distinct positions, drawing one candidate position per clock and discarding repeats and out-of-range draws. When a fault fires, the block raises a one-cycle event strobe that carries the target index and the mask. A scoreboard can use this to score detection coverage against the faults actually injected.

Top module: `fi_fault_injector`

## Requirements
- R1: While reset is held and in the first cycle after it, `evt_valid` is 0, `evt_mask` is all zeros and every element's output word equals its input word.
- R2: In every cycle, the output word of each element that is not the current event target equals that element's input word in the same cycle. With `evt_valid` low, this applies to every element.
- R3: In a cycle with `evt_valid` high, the output word of element `evt_pe` equals its input word XOR `evt_mask` in that same cycle. Element p occupies bits [p*DATA_W +: DATA_W] of the data buses.
- R4: The number of ones in `evt_mask` during an event equals the requested flip count, limited to 1..4. A request of 0 acts as 1, and a request of 5, 6 or 7 acts as 4.
- R5: An event is shown in a cycle only if, in the cycle before, `inject_en` was 1 and `pe_busy` bit `evt_pe` was 1.
- R6: With `rate` at 0, no event is raised. A fire decision is taken on a cycle when the LFSR rate field is below `rate`, so a larger `rate` gives more events.
- R7: `evt_valid` is never high in two consecutive cycles, and `evt_mask` is all zeros whenever `evt_valid` is low.
- R8: `evt_pe` is always below NUM_PE during an event.
- R9: After the flip count changes, any partly built mask is dropped. The next event carries the count that was present in the cycle before that event.
- R10: With all elements busy and the rate at maximum, every element is chosen as a target during a run of a few hundred cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inject_en | input | 1 | Allows fault firing |
| rate | input | RATE_W | Per-clock fire threshold; the probability is rate/2^RATE_W |
| flip_count | input | 3 | Bits flipped per fault; limited to 1..4 |
| pe_busy | input | NUM_PE | Task-executing flag for each element |
| pe_data_in | input | NUM_PE*DATA_W | Clean data words, element p at [p*DATA_W +: DATA_W] |
| pe_data_out | output | NUM_PE*DATA_W | Data words with the current fault applied |
| evt_valid | output | 1 | One-cycle fault strobe |
| evt_pe | output | IDX_W | Index of the element receiving the fault |
| evt_mask | output | DATA_W | Flip mask applied in this cycle; zero when idle |

## Verification
The fire decision is registered once. A fault therefore shows up on the strobe, index and mask one clock after the cycle whose enable, rate, busy flags and flip count permitted it. The XOR onto the data is combinational, in the same cycle as the strobe. The bench changes inputs just after the falling edge and samples one time unit later. It keeps the settings of the previous cycle to judge each strobe against the busy, enable, rate and count that produced it, and it compares every output word against the input word driven in that same cycle. The first cycle of each stimulus row is left out of the event tallies, because a fault seen there belongs to the row before.

// File: rtl/fi_pkg.sv
`timescale 1ns/1ps
package fi_pkg;

   localparam int FI_MAX_FLIPS = 4;
   localparam int FI_CNT_W     = 3;

   typedef logic [FI_CNT_W-1:0] fi_cnt_t;

   // Requested flips are limited to 1..FI_MAX_FLIPS.
   function automatic fi_cnt_t fi_limit_flips(input fi_cnt_t req);
      fi_cnt_t r;
      if (req == '0)
         r = fi_cnt_t'(1);
      else if (int'(req) > FI_MAX_FLIPS)
         r = fi_cnt_t'(FI_MAX_FLIPS);
      else
         r = req;
      return r;
   endfunction

endpackage

// File: rtl/fi_lfsr.sv
`timescale 1ns/1ps
module fi_lfsr #(
   parameter int           W    = 32,
   parameter logic [W-1:0] SEED = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] state
);

   logic [W-1:0] nxt;

   // Galois right-shift form; the feedback polynomial is chosen per width.
   generate
      if (W == 16) begin : g_w16
         localparam logic [W-1:0] TAPS = W'(32'h0000_B400);
         assign nxt = state[0] ? ((state >> 1) ^ TAPS) : (state >> 1);
      end else if (W == 24) begin : g_w24
         localparam logic [W-1:0] TAPS = W'(32'h00E1_0000);
         assign nxt = state[0] ? ((state >> 1) ^ TAPS) : (state >> 1);
      end else if (W == 32) begin : g_w32
         localparam logic [W-1:0] TAPS = W'(32'h8020_0003);
         assign nxt = state[0] ? ((state >> 1) ^ TAPS) : (state >> 1);
      end else begin : g_bad_width
         $error("fi_lfsr: width must be 16, 24 or 32");
         assign nxt = state;
      end
      if (SEED == '0) begin : g_bad_seed
         $error("fi_lfsr: seed must be nonzero");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= SEED;
      else
         state <= nxt;
   end

endmodule

// File: rtl/fi_mask_builder.sv
`timescale 1ns/1ps
module fi_mask_builder
   import fi_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int POS_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fi_cnt_t           need,
   input  logic [POS_W-1:0]  draw_pos,
   input  logic              consume,
   output logic [DATA_W-1:0] mask,
   output logic              ready
);

   fi_cnt_t           need_q;
   fi_cnt_t           cnt_q;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] cand;
   logic              cand_ok;
   logic              count_changed;
   logic              filling;

   // A draw beyond the word gives an empty candidate and is discarded.
   assign cand          = DATA_W'(1) << draw_pos;
   assign cand_ok       = (cand != '0) && ((cand & mask_q) == '0);
   assign count_changed = (need != need_q);
   assign filling       = (cnt_q != need_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         need_q <= fi_cnt_t'(1);
         cnt_q  <= '0;
         mask_q <= '0;
      end else if (count_changed) begin
         need_q <= need;
         cnt_q  <= '0;
         mask_q <= '0;
      end else if (consume) begin
         cnt_q  <= '0;
         mask_q <= '0;
      end else if (filling && cand_ok) begin
         cnt_q  <= cnt_q + fi_cnt_t'(1);
         mask_q <= mask_q | cand;
      end
   end

   assign mask  = mask_q;
   assign ready = !count_changed && !filling;

endmodule

// File: rtl/fi_trigger.sv
`timescale 1ns/1ps
module fi_trigger #(
   parameter int NUM_PE = 4,
   parameter int RATE_W = 8,
   parameter int IDX_W  = 2
) (
   input  logic              enable,
   input  logic [RATE_W-1:0] rate,
   input  logic [RATE_W-1:0] rand_rate,
   input  logic [IDX_W-1:0]  rand_idx,
   input  logic [NUM_PE-1:0] busy,
   input  logic              mask_ready,
   output logic              fire,
   output logic [IDX_W-1:0]  target
);

   localparam int SLOTS = 1 << IDX_W;

   logic [SLOTS-1:0] busy_ext;
   logic             idx_ok;
   logic             hit_busy;
   logic             roll_ok;

   generate
      if (SLOTS > NUM_PE) begin : g_pad
         assign busy_ext = {{(SLOTS-NUM_PE){1'b0}}, busy};
      end else begin : g_exact
         assign busy_ext = busy;
      end
   endgenerate

   assign idx_ok   = (int'(rand_idx) < NUM_PE);
   assign hit_busy = busy_ext[rand_idx];
   assign roll_ok  = (rand_rate < rate);
   assign fire     = enable && mask_ready && roll_ok && idx_ok && hit_busy;
   assign target   = rand_idx;

endmodule

// File: rtl/fi_corrupt.sv
`timescale 1ns/1ps
module fi_corrupt #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] clean,
   input  logic              hit,
   input  logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] dirty
);

   assign dirty = hit ? (clean ^ mask) : clean;

endmodule

// File: rtl/fi_fault_injector.sv
`timescale 1ns/1ps
module fi_fault_injector
   import fi_pkg::*;
#(
   parameter int          NUM_PE    = 4,
   parameter int          DATA_W    = 16,
   parameter int          RATE_W    = 8,
   parameter int          LFSR_W    = 32,
   parameter logic [31:0] LFSR_SEED = 32'h5EED_C0DE,
   localparam int         IDX_W     = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     inject_en,
   input  logic [RATE_W-1:0]        rate,
   input  logic [FI_CNT_W-1:0]      flip_count,
   input  logic [NUM_PE-1:0]        pe_busy,
   input  logic [NUM_PE*DATA_W-1:0] pe_data_in,
   output logic [NUM_PE*DATA_W-1:0] pe_data_out,
   output logic                     evt_valid,
   output logic [IDX_W-1:0]         evt_pe,
   output logic [DATA_W-1:0]        evt_mask
);

   localparam int POS_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam int USED  = RATE_W + IDX_W + POS_W;

   generate
      if (NUM_PE < 1) begin : g_bad_pe
         $error("fi_fault_injector: NUM_PE must be at least 1");
      end
      if (DATA_W < FI_MAX_FLIPS) begin : g_bad_data
         $error("fi_fault_injector: DATA_W too narrow for the largest flip count");
      end
      if (LFSR_W < USED) begin : g_bad_lfsr
         $error("fi_fault_injector: LFSR too narrow for the random fields");
      end
      if (RATE_W < 1) begin : g_bad_rate
         $error("fi_fault_injector: RATE_W must be at least 1");
      end
   endgenerate

   logic [LFSR_W-1:0] rnd;
   logic [RATE_W-1:0] rnd_rate;
   logic [IDX_W-1:0]  rnd_idx;
   logic [POS_W-1:0]  rnd_pos;
   logic              unused_rnd_bits;
   fi_cnt_t           need;
   logic [DATA_W-1:0] built_mask;
   logic              built_ready;
   logic              fire;
   logic [IDX_W-1:0]  fire_pe;
   logic              ev_q;
   logic [IDX_W-1:0]  ev_pe_q;
   logic [DATA_W-1:0] ev_mask_q;

   fi_lfsr #(
      .W    (LFSR_W),
      .SEED (LFSR_W'(LFSR_SEED))
   ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .state (rnd)
   );

   // Separate fields of one state word: rate roll, target, bit position.
   assign rnd_rate        = rnd[RATE_W-1:0];
   assign rnd_idx         = rnd[RATE_W +: IDX_W];
   assign rnd_pos         = rnd[LFSR_W-1 -: POS_W];
   assign unused_rnd_bits = ^rnd;

   assign need = fi_limit_flips(flip_count);

   fi_mask_builder #(
      .DATA_W (DATA_W),
      .POS_W  (POS_W)
   ) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .need     (need),
      .draw_pos (rnd_pos),
      .consume  (fire),
      .mask     (built_mask),
      .ready    (built_ready)
   );

   fi_trigger #(
      .NUM_PE (NUM_PE),
      .RATE_W (RATE_W),
      .IDX_W  (IDX_W)
   ) u_trig (
      .enable     (inject_en),
      .rate       (rate),
      .rand_rate  (rnd_rate),
      .rand_idx   (rnd_idx),
      .busy       (pe_busy),
      .mask_ready (built_ready),
      .fire       (fire),
      .target     (fire_pe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_q      <= 1'b0;
         ev_pe_q   <= '0;
         ev_mask_q <= '0;
      end else if (fire) begin
         ev_q      <= 1'b1;
         ev_pe_q   <= fire_pe;
         ev_mask_q <= built_mask;
      end else begin
         ev_q      <= 1'b0;
         ev_mask_q <= '0;
      end
   end

   generate
      for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
         logic hit;
         assign hit = ev_q && (int'(ev_pe_q) == p);
         fi_corrupt #(
            .DATA_W (DATA_W)
         ) u_corrupt (
            .clean (pe_data_in[p*DATA_W +: DATA_W]),
            .hit   (hit),
            .mask  (ev_mask_q),
            .dirty (pe_data_out[p*DATA_W +: DATA_W])
         );
      end
   endgenerate

   assign evt_valid = ev_q;
   assign evt_pe    = ev_pe_q;
   assign evt_mask  = ev_mask_q;

endmodule

// File: rtl/fi_fault_injector_chk.sv
`timescale 1ns/1ps
module fi_fault_injector_chk
   import fi_pkg::*;
#(
   parameter int NUM_PE = 4,
   parameter int DATA_W = 16,
   parameter int RATE_W = 8,
   parameter int IDX_W  = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                inject_en,
   input logic [RATE_W-1:0]   rate,
   input logic [NUM_PE-1:0]   pe_busy,
   input logic                evt_valid,
   input logic [IDX_W-1:0]    evt_pe,
   input logic [DATA_W-1:0]   evt_mask
);

   assert_idle_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid |-> (evt_mask == '0));

   assert_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |=> !evt_valid);

   assert_flip_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> ($countones(evt_mask) >= 1 && $countones(evt_mask) <= FI_MAX_FLIPS));

   assert_busy_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> ((($past(pe_busy) >> evt_pe) & NUM_PE'(1)) != '0));

   assert_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> $past(inject_en));

   assert_zero_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> ($past(rate) != '0));

   assert_target_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> (int'(evt_pe) < NUM_PE));

endmodule

bind fi_fault_injector fi_fault_injector_chk #(
   .NUM_PE (NUM_PE),
   .DATA_W (DATA_W),
   .RATE_W (RATE_W),
   .IDX_W  (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .inject_en (inject_en),
   .rate      (rate),
   .pe_busy   (pe_busy),
   .evt_valid (evt_valid),
   .evt_pe    (evt_pe),
   .evt_mask  (evt_mask)
);

// File: tb/sim_fi_fault_injector.sv
`timescale 1ns/1ps
module sim_fi_fault_injector;

   localparam int NPE = 4;
   localparam int DW  = 16;
   localparam int RW  = 8;

   typedef struct packed {
      logic        en;
      logic [7:0]  rate;
      logic [2:0]  fc;
      logic [3:0]  busy;
      logic [15:0] cycles;
      logic [15:0] min_ev;
      logic [15:0] max_ev;
   } vec_t;

   localparam int NVEC = 9;
   localparam vec_t VECS [0:NVEC-1] = '{
      '{1'b1, 8'd255, 3'd1, 4'b1111, 16'd200, 16'd20, 16'd200}, // R10 coverage, R3
      '{1'b1, 8'd255, 3'd4, 4'b0100, 16'd200, 16'd5,  16'd200}, // R5 single busy
      '{1'b0, 8'd255, 3'd2, 4'b1111, 16'd100, 16'd0,  16'd0},   // R5 disabled
      '{1'b1, 8'd0,   3'd3, 4'b1111, 16'd100, 16'd0,  16'd0},   // R6 zero rate
      '{1'b1, 8'd255, 3'd2, 4'b0000, 16'd100, 16'd0,  16'd0},   // R5 none busy
      '{1'b1, 8'd64,  3'd2, 4'b1010, 16'd400, 16'd5,  16'd200}, // R6 partial rate
      '{1'b1, 8'd255, 3'd0, 4'b1111, 16'd100, 16'd10, 16'd100}, // R4 zero acts as 1
      '{1'b1, 8'd255, 3'd7, 4'b1111, 16'd100, 16'd5,  16'd100}, // R4 seven acts as 4
      '{1'b1, 8'd255, 3'd3, 4'b1001, 16'd150, 16'd5,  16'd150}  // R9 count change
   };

   logic                 clk = 1'b0;
   logic                 rst_n;
   logic                 inject_en;
   logic [RW-1:0]        rate;
   logic [2:0]           flip_count;
   logic [NPE-1:0]       pe_busy;
   logic [NPE*DW-1:0]    pe_data_in;
   logic [NPE*DW-1:0]    pe_data_out;
   logic                 evt_valid;
   logic [1:0]           evt_pe;
   logic [DW-1:0]        evt_mask;

   int checks = 0;
   int fails  = 0;

   logic           prev_en,   cur_en;
   logic [RW-1:0]  prev_rate, cur_rate;
   logic [2:0]     prev_fc,   cur_fc;
   logic [NPE-1:0] prev_busy, cur_busy;
   logic           last_ev;
   int             hits [NPE];

   always #4 clk = ~clk;

   fi_fault_injector u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .inject_en   (inject_en),
      .rate        (rate),
      .flip_count  (flip_count),
      .pe_busy     (pe_busy),
      .pe_data_in  (pe_data_in),
      .pe_data_out (pe_data_out),
      .evt_valid   (evt_valid),
      .evt_pe      (evt_pe),
      .evt_mask    (evt_mask)
   );

   function automatic int limit_fc(input int r);
      if (r == 0) return 1;
      if (r > 4) return 4;
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_now();
      for (int p = 0; p < NPE; p++) begin
         logic [DW-1:0] exp_w;
         logic [DW-1:0] act_w;
         bit            tgt;
         tgt   = evt_valid && (int'(evt_pe) == p);
         exp_w = pe_data_in[p*DW +: DW];
         if (tgt) exp_w = exp_w ^ evt_mask;
         act_w = pe_data_out[p*DW +: DW];
         chk(act_w == exp_w, tgt ? "R3" : "R2", "data word", act_w, exp_w);
      end
      if (evt_valid) begin
         chk($countones(evt_mask) == limit_fc(int'(prev_fc)), "R4/R9", "mask ones",
             $countones(evt_mask), limit_fc(int'(prev_fc)));
         chk(prev_en && prev_busy[evt_pe], "R5", "enable and busy before event",
             {prev_en, prev_busy}, 1);
         chk(prev_rate != '0, "R6", "rate before event", prev_rate, 1);
         chk(int'(evt_pe) < NPE, "R8", "target index", evt_pe, NPE - 1);
         chk(!last_ev, "R7", "back-to-back strobe", last_ev, 0);
      end else begin
         chk(evt_mask == '0, "R7", "idle mask", evt_mask, 0);
      end
   endtask

   task automatic cycle(input logic en, input logic [RW-1:0] rt, input logic [2:0] fc,
                        input logic [NPE-1:0] bz);
      @(negedge clk);
      prev_en   = cur_en;
      prev_rate = cur_rate;
      prev_fc   = cur_fc;
      prev_busy = cur_busy;
      cur_en    = en;
      cur_rate  = rt;
      cur_fc    = fc;
      cur_busy  = bz;
      inject_en  = en;
      rate       = rt;
      flip_count = fc;
      pe_busy    = bz;
      pe_data_in = {$urandom, $urandom};
      #1;
      check_now();
      last_ev = evt_valid;
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n      = 1'b0;
      cur_en     = 1'b1;  cur_rate  = 8'd255; cur_fc  = 3'd1; cur_busy  = 4'hF;
      prev_en    = 1'b1;  prev_rate = 8'd255; prev_fc = 3'd1; prev_busy = 4'hF;
      last_ev    = 1'b0;
      for (int p = 0; p < NPE; p++) hits[p] = 0;

      // R1: held in reset with injection fully permitted
      for (int i = 0; i < 4; i++) begin
         cycle(1'b1, 8'd255, 3'd1, 4'hF);
         chk(evt_valid == 1'b0, "R1", "strobe in reset", evt_valid, 0);
         chk(evt_mask == '0, "R1", "mask in reset", evt_mask, 0);
         chk(pe_data_out == pe_data_in, "R1", "pass-through in reset", pe_data_out, pe_data_in);
      end
      @(negedge clk);
      rst_n = 1'b1;
      cycle(1'b1, 8'd255, 3'd1, 4'hF);
      chk(evt_valid == 1'b0, "R1", "strobe after reset", evt_valid, 0);

      // table walk
      for (int v = 0; v < NVEC; v++) begin
         int n_ev;
         n_ev = 0;
         for (int i = 0; i < int'(VECS[v].cycles); i++) begin
            cycle(VECS[v].en, VECS[v].rate, VECS[v].fc, VECS[v].busy);
            if (i > 0 && evt_valid) begin
               n_ev++;
               if (v == 0) hits[evt_pe]++;
            end
         end
         chk(n_ev >= int'(VECS[v].min_ev), v == 0 ? "R10" : "R6", "event count low bound",
             n_ev, VECS[v].min_ev);
         chk(n_ev <= int'(VECS[v].max_ev), "R6", "event count high bound", n_ev, VECS[v].max_ev);
         if (v == 0) begin
            for (int p = 0; p < NPE; p++)
               chk(hits[p] > 0, "R10", "element chosen", hits[p], 1);
         end
      end

      // R9: flip count changes every few cycles; every event must match the count seen before it
      for (int i = 0; i < 120; i++)
         cycle(1'b1, 8'd255, 3'((i / 3) % 4 + 1), 4'hF);

      // R1: reset in the middle of an active run
      for (int i = 0; i < 40; i++) begin
         cycle(1'b1, 8'd255, 3'd1, 4'hF);
         if (evt_valid) break;
      end
      #1;
      rst_n = 1'b0;
      #1;
      chk(evt_valid == 1'b0, "R1", "strobe cleared by reset", evt_valid, 0);
      chk(evt_mask == '0, "R1", "mask cleared by reset", evt_mask, 0);
      chk(pe_data_out == pe_data_in, "R1", "pass-through after reset", pe_data_out, pe_data_in);
      last_ev = 1'b0;
      cycle(1'b1, 8'd255, 3'd1, 4'hF);
      chk(evt_valid == 1'b0, "R1", "no strobe while in reset", evt_valid, 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 20; i++)
         cycle(1'b1, 8'd255, 3'd2, 4'hF);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule